// File: doc/BRIEF.md
# Key-Protected Watchdog Timer

This block is a watchdog counter whose control state is guarded by a two-key unlock. Software opens the gate with two writes. The first write puts one key value at one address. The second write puts a second key value at a second address. The gate then accepts exactly one write to a guarded register and closes again. The guarded registers are the match value, the enable bits and the status. Any write to a guarded register while the gate is closed has no effect and sets a sticky violation flag.

When counting is enabled, the counter advances by one on every cycle in which `tick` is high. If a tick arrives while the count equals the match value, the watchdog fires. Firing sets the event bit in the status register and sends the counter back to zero. If reset driving is also enabled, firing starts a reset pulse of fixed length on `wdt_rst_o`. The current count can be read at its own address. All registers sit on a plain address, write-data and write-strobe bus, and read data is a combinational function of the address.

Top module: `wdt_keyed_top`

## Requirements
- R1: Reset behaviour. After a synchronous reset the gate is closed and match reads 0xFFFF. Enable, status and count all read 0, and both `wdt_rst_o` and `viol_o` are low.
- R2: Opening the gate. Writing 0xBABA to address 0 and then 0xEB10 to address 1 opens it. The next write to a guarded register then takes effect. The guarded registers are match (address 2), enable (address 3) and status (address 4).
- R3: One write per unlock. After one guarded write has been accepted, further guarded writes are ignored until a new pair of keys is written.
- R4: Bad keys close the gate. A wrong value at either key address closes it. So does a correct second key that does not follow a valid first key. A guarded write after either case is ignored.
- R5: Violation flag. A guarded write while the gate is closed changes nothing and sets a sticky violation flag. The flag is seen on `viol_o` and in status bit 1. Only an accepted status write with bit 1 equal to 0 clears it.
- R6: Counting and firing. While enable bit 0 is set, each tick adds one to the count, which reads at address 5. A tick that arrives while the count equals the match value sets status bit 0 and returns the count to 0. While enable bit 0 is clear, the count holds.
- R7: Reset pulse. If enable bit 1 is set when the watchdog fires, `wdt_rst_o` goes high from the cycle after the firing tick. It stays high for exactly 16 cycles.
- R8: Clearing the event. An accepted status write with bit 0 equal to 0 clears the event bit. If a firing tick lands in the same cycle, the event bit stays set.
- R9: Restart on match write. Every accepted write to the match register restarts the count at 0. This holds even when a tick arrives in the same cycle.
- R10: Other addresses do not touch the gate. Writes to addresses 5 to 7 leave the unlock state unchanged. An open gate stays open through such a write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Count enable pulse, one increment per high cycle |
| bus_we | input | 1 | Write strobe |
| bus_addr | input | 3 | Register address for both read and write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` |
| wdt_rst_o | output | 1 | Stretched reset request |
| viol_o | output | 1 | Sticky flag for a guarded write that was refused |

## Verification
Two pairs of events can meet in one cycle. The first pair is an accepted status clear and a firing tick. The second pair is an accepted match write and a counting tick. The bench sets up each pair by driving `tick` high in the same cycle as the unlocked write. For the first pair, the status must still show the event while the violation bit clears. For the second pair, the count must read zero, with neither increment nor firing.

// File: rtl/wdt_keyed_pkg.sv
`timescale 1ns/1ps
package wdt_keyed_pkg;

    localparam int ADDR_W = 3;

    // register addresses
    localparam logic [ADDR_W-1:0] A_KEY_FIRST  = 3'd0;
    localparam logic [ADDR_W-1:0] A_KEY_SECOND = 3'd1;
    localparam logic [ADDR_W-1:0] A_MATCH      = 3'd2;
    localparam logic [ADDR_W-1:0] A_ENABLE     = 3'd3;
    localparam logic [ADDR_W-1:0] A_STATUS     = 3'd4;
    localparam logic [ADDR_W-1:0] A_COUNT      = 3'd5;

    // unlock key values
    localparam logic [15:0] KEY_FIRST  = 16'hBABA;
    localparam logic [15:0] KEY_SECOND = 16'hEB10;

    typedef enum logic [1:0] {
        UL_LOCKED = 2'd0,
        UL_HALF   = 2'd1,
        UL_OPEN   = 2'd2
    } unlock_e;

    typedef struct packed {
        logic rst_drive;   // bit 1
        logic cmp_en;      // bit 0
    } enable_t;

    typedef struct packed {
        logic viol;        // bit 1
        logic event_hit;   // bit 0
    } status_t;

    function automatic logic is_guarded(logic [ADDR_W-1:0] a);
        return (a == A_MATCH) || (a == A_ENABLE) || (a == A_STATUS);
    endfunction

endpackage

// File: rtl/wdt_unlock.sv
`timescale 1ns/1ps
module wdt_unlock
    import wdt_keyed_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic              accept_o,
    output logic              refuse_o
);

    localparam logic [DATA_W-1:0] KEY1_EXT = DATA_W'(KEY_FIRST);
    localparam logic [DATA_W-1:0] KEY2_EXT = DATA_W'(KEY_SECOND);

    unlock_e st_q, st_d;
    logic    accept, refuse;

    always_comb begin
        st_d   = st_q;
        accept = 1'b0;
        refuse = 1'b0;
        if (we) begin
            if (addr == A_KEY_FIRST) begin
                st_d = (wdata == KEY1_EXT) ? UL_HALF : UL_LOCKED;
            end else if (addr == A_KEY_SECOND) begin
                st_d = (st_q == UL_HALF && wdata == KEY2_EXT) ? UL_OPEN : UL_LOCKED;
            end else if (is_guarded(addr)) begin
                accept = (st_q == UL_OPEN);
                refuse = (st_q != UL_OPEN);
                st_d   = UL_LOCKED;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= UL_LOCKED;
        else     st_q <= st_d;
    end

    assign accept_o = accept;
    assign refuse_o = refuse;

    // R3: any guarded write consumes the unlock
    a_r3_unlock_consumed: assert property (@(posedge clk) disable iff (rst)
        (we && is_guarded(addr)) |=> (st_q == UL_LOCKED));

    // R4: second key without a pending first key closes the gate
    a_r4_bad_second_relocks: assert property (@(posedge clk) disable iff (rst)
        (we && addr == A_KEY_SECOND && st_q != UL_HALF) |=> (st_q == UL_LOCKED));

    // R10: writes outside key and guarded space keep the state
    a_r10_other_keeps_state: assert property (@(posedge clk) disable iff (rst)
        (we && addr != A_KEY_FIRST && addr != A_KEY_SECOND && !is_guarded(addr))
        |=> $stable(st_q));

endmodule

// File: rtl/wdt_counter.sv
`timescale 1ns/1ps
module wdt_counter #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    input  logic             en,
    input  logic             restart,
    input  logic [CNT_W-1:0] match,
    output logic [CNT_W-1:0] count_o,
    output logic             hit_o
);

    logic [CNT_W-1:0] count_q;
    logic             step;
    logic             hit;

    assign step = tick && en && !restart;
    assign hit  = step && (count_q == match);

    always_ff @(posedge clk) begin
        if (rst) begin
            count_q <= '0;
        end else if (restart) begin
            count_q <= '0;
        end else if (step) begin
            count_q <= hit ? '0 : count_q + 1'b1;
        end
    end

    assign count_o = count_q;
    assign hit_o   = hit;

    // R9: accepted match write zeroes the count
    a_r9_restart_zero: assert property (@(posedge clk) disable iff (rst)
        restart |=> (count_q == '0));

    // R6: disabled counter holds
    a_r6_hold_disabled: assert property (@(posedge clk) disable iff (rst)
        (!en && !restart) |=> $stable(count_q));

    // R6: firing sends count back to zero
    a_r6_fire_wraps: assert property (@(posedge clk) disable iff (rst)
        hit_o |=> (count_q == '0));

endmodule

// File: rtl/wdt_pulse.sv
`timescale 1ns/1ps
module wdt_pulse #(
    parameter int CYCLES = 16
) (
    input  logic clk,
    input  logic rst,
    input  logic fire,
    input  logic arm,
    output logic pulse_o
);

    localparam int PW = $clog2(CYCLES + 1);
    localparam logic [PW-1:0] LOAD = PW'(CYCLES);

    logic [PW-1:0] left_q;
    logic          start;

    assign start = fire && arm;

    always_ff @(posedge clk) begin
        if (rst) begin
            left_q <= '0;
        end else if (start) begin
            left_q <= LOAD;
        end else if (left_q != '0) begin
            left_q <= left_q - 1'b1;
        end
    end

    assign pulse_o = (left_q != '0);

    // R7: armed firing raises the pulse in the next cycle
    a_r7_pulse_starts: assert property (@(posedge clk) disable iff (rst)
        start |=> pulse_o);

    // R7: remaining length never exceeds the configured width
    a_r7_len_bound: assert property (@(posedge clk) disable iff (rst)
        left_q <= LOAD);

    // R7: no pulse appears without an armed firing
    a_r7_no_spontaneous: assert property (@(posedge clk) disable iff (rst)
        (!pulse_o && !start) |=> !pulse_o);

endmodule

// File: rtl/wdt_keyed_top.sv
`timescale 1ns/1ps
module wdt_keyed_top
    import wdt_keyed_pkg::*;
#(
    parameter int DATA_W     = 32,
    parameter int CNT_W      = 16,
    parameter int RST_CYCLES = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick,
    input  logic              bus_we,
    input  logic [2:0]        bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              wdt_rst_o,
    output logic              viol_o
);

    logic             accept, refuse;
    logic             wr_match, wr_enable, wr_status;
    logic [CNT_W-1:0] match_q;
    enable_t          en_q;
    status_t          st_q;
    logic [CNT_W-1:0] count;
    logic             hit;

    wdt_unlock #(.DATA_W(DATA_W)) u_unlock (
        .clk      (clk),
        .rst      (rst),
        .we       (bus_we),
        .addr     (bus_addr),
        .wdata    (bus_wdata),
        .accept_o (accept),
        .refuse_o (refuse)
    );

    assign wr_match  = accept && (bus_addr == A_MATCH);
    assign wr_enable = accept && (bus_addr == A_ENABLE);
    assign wr_status = accept && (bus_addr == A_STATUS);

    // guarded configuration
    always_ff @(posedge clk) begin
        if (rst) begin
            match_q <= '1;
            en_q    <= '0;
        end else begin
            if (wr_match)  match_q <= bus_wdata[CNT_W-1:0];
            if (wr_enable) en_q    <= enable_t'(bus_wdata[1:0]);
        end
    end

    // status: new events outrank a clearing write
    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            if (hit)                          st_q.event_hit <= 1'b1;
            else if (wr_status && !bus_wdata[0]) st_q.event_hit <= 1'b0;
            if (refuse)                       st_q.viol <= 1'b1;
            else if (wr_status && !bus_wdata[1]) st_q.viol <= 1'b0;
        end
    end

    wdt_counter #(.CNT_W(CNT_W)) u_counter (
        .clk     (clk),
        .rst     (rst),
        .tick    (tick),
        .en      (en_q.cmp_en),
        .restart (wr_match),
        .match   (match_q),
        .count_o (count),
        .hit_o   (hit)
    );

    wdt_pulse #(.CYCLES(RST_CYCLES)) u_pulse (
        .clk     (clk),
        .rst     (rst),
        .fire    (hit),
        .arm     (en_q.rst_drive),
        .pulse_o (wdt_rst_o)
    );

    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            A_MATCH:  bus_rdata = DATA_W'(match_q);
            A_ENABLE: bus_rdata = DATA_W'(en_q);
            A_STATUS: bus_rdata = DATA_W'(st_q);
            A_COUNT:  bus_rdata = DATA_W'(count);
            default:  bus_rdata = '0;
        endcase
    end

    assign viol_o = st_q.viol;

    // R6: count never passes the match value
    a_r6_count_bounded: assert property (@(posedge clk) disable iff (rst)
        count <= match_q);

    // R8: a firing tick always leaves the event bit set
    a_r8_event_kept: assert property (@(posedge clk) disable iff (rst)
        hit |=> st_q.event_hit);

    // R5: refused writes leave configuration untouched
    a_r5_locked_ignored: assert property (@(posedge clk) disable iff (rst)
        refuse |=> ($stable(match_q) && $stable(en_q)));

    // R5: violation flag is sticky
    a_r5_viol_sticky: assert property (@(posedge clk) disable iff (rst)
        (st_q.viol && !(wr_status && !bus_wdata[1])) |=> st_q.viol);

endmodule

// File: tb/sim_wdt_keyed_top.sv
`timescale 1ns/1ps
module sim_wdt_keyed_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        tick = 1'b0;
    logic        bus_we = 1'b0;
    logic [2:0]  bus_addr = 3'd0;
    logic [31:0] bus_wdata = 32'd0;
    logic [31:0] bus_rdata;
    logic        wdt_rst_o;
    logic        viol_o;

    int n_chk  = 0;
    int n_fail = 0;

    always #2.5 clk = ~clk;

    wdt_keyed_top u0 (
        .clk       (clk),
        .rst       (rst),
        .tick      (tick),
        .bus_we    (bus_we),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .wdt_rst_o (wdt_rst_o),
        .viol_o    (viol_o)
    );

    // op: 0 write, 1 read and compare, 2 tick data times
    typedef struct packed {
        logic [1:0]  op;
        logic [2:0]  addr;
        logic [31:0] data;
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 30;
    localparam vec_t VECS [NV] = '{
        '{2'd0, 3'd0, 32'hBABA, 4'd2},   // R2 unlock
        '{2'd0, 3'd1, 32'hEB10, 4'd2},
        '{2'd0, 3'd2, 32'h0005, 4'd2},
        '{2'd1, 3'd2, 32'h0005, 4'd2},
        '{2'd0, 3'd2, 32'h0009, 4'd3},   // R3 second write refused
        '{2'd1, 3'd2, 32'h0005, 4'd3},
        '{2'd1, 3'd4, 32'h0002, 4'd5},   // R5 violation bit
        '{2'd0, 3'd0, 32'hBABA, 4'd4},   // R4 wrong second key
        '{2'd0, 3'd1, 32'h1234, 4'd4},
        '{2'd0, 3'd3, 32'h0003, 4'd4},
        '{2'd1, 3'd3, 32'h0000, 4'd4},
        '{2'd0, 3'd1, 32'hEB10, 4'd4},   // R4 second key alone
        '{2'd0, 3'd3, 32'h0001, 4'd4},
        '{2'd1, 3'd3, 32'h0000, 4'd4},
        '{2'd0, 3'd0, 32'hBABA, 4'd10},  // R10 count-address write
        '{2'd0, 3'd1, 32'hEB10, 4'd10},
        '{2'd0, 3'd5, 32'h0000, 4'd10},
        '{2'd0, 3'd4, 32'h0000, 4'd10},
        '{2'd1, 3'd4, 32'h0000, 4'd10},
        '{2'd0, 3'd0, 32'hBABA, 4'd6},   // R6 counting
        '{2'd0, 3'd1, 32'hEB10, 4'd6},
        '{2'd0, 3'd3, 32'h0001, 4'd6},
        '{2'd2, 3'd0, 32'd3,    4'd6},
        '{2'd1, 3'd5, 32'd3,    4'd6},
        '{2'd2, 3'd0, 32'd2,    4'd6},
        '{2'd1, 3'd5, 32'd5,    4'd6},
        '{2'd1, 3'd4, 32'd0,    4'd6},
        '{2'd2, 3'd0, 32'd1,    4'd6},
        '{2'd1, 3'd5, 32'd0,    4'd6},
        '{2'd1, 3'd4, 32'd1,    4'd6}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(input string req, input logic [2:0] a, input logic [31:0] exp);
        bus_addr = a;
        #1;
        chk(req, bus_rdata, exp);
    endtask

    task automatic ticks(input int n);
        for (int k = 0; k < n; k++) begin
            tick = 1'b1;
            @(negedge clk);
        end
        tick = 1'b0;
    endtask

    task automatic unlock();
        wr(3'd0, 32'hBABA);
        wr(3'd1, 32'hEB10);
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual hung expected finished");
        summary();
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        rd("R1", 3'd2, 32'h0000FFFF);
        rd("R1", 3'd3, 32'h0);
        rd("R1", 3'd4, 32'h0);
        rd("R1", 3'd5, 32'h0);
        chk("R1", {31'd0, wdt_rst_o}, 32'd0);
        chk("R1", {31'd0, viol_o}, 32'd0);
        wr(3'd3, 32'h1);                 // R1 gate closed: refused
        rd("R1", 3'd3, 32'h0);
        unlock();
        wr(3'd4, 32'h0);                 // clear that violation

        for (int i = 0; i < NV; i++) begin
            case (VECS[i].op)
                2'd0: wr(VECS[i].addr, VECS[i].data);
                2'd1: rd($sformatf("R%0d", VECS[i].req), VECS[i].addr, VECS[i].data);
                default: ticks(int'(VECS[i].data));
            endcase
        end

        // R5 refused write shows on the port
        wr(3'd3, 32'h3);
        chk("R5", {31'd0, viol_o}, 32'd1);
        rd("R5", 3'd3, 32'h1);

        // R7 reset pulse length
        unlock(); wr(3'd3, 32'h3);
        unlock(); wr(3'd2, 32'h2);
        ticks(2);
        chk("R7", {31'd0, wdt_rst_o}, 32'd0);
        tick = 1'b1;
        @(negedge clk);
        tick = 1'b0;
        chk("R7", {31'd0, wdt_rst_o}, 32'd1);
        begin
            int hi = 0;
            while (wdt_rst_o && hi < 100) begin
                hi++;
                @(negedge clk);
            end
            chk("R7", hi, 32'd16);
        end

        // R8 clear and fire in the same cycle
        unlock(); wr(3'd3, 32'h1);
        ticks(2);
        rd("R8", 3'd5, 32'd2);
        unlock();
        tick = 1'b1;
        wr(3'd4, 32'h0);
        tick = 1'b0;
        rd("R8", 3'd4, 32'h1);
        rd("R8", 3'd5, 32'h0);
        unlock(); wr(3'd4, 32'h0);
        rd("R8", 3'd4, 32'h0);

        // R9 match write beats a same-cycle tick
        ticks(1);
        rd("R9", 3'd5, 32'd1);
        unlock();
        tick = 1'b1;
        wr(3'd2, 32'h7);
        tick = 1'b0;
        rd("R9", 3'd5, 32'd0);
        rd("R9", 3'd2, 32'd7);
        rd("R9", 3'd4, 32'd0);

        summary();
        $finish;
    end

endmodule